// File: doc/BRIEF.md
# E3 Transmit Framer with Externally Timed Frame Start

This block forms the outgoing E3 line bit stream from a serial payload stream. Each frame is 1536 bit slots long. The first twelve slots carry overhead: a ten-bit alignment word, then an alarm bit, then a national bit. The remaining 1524 slots carry payload taken from the serial input. The payload, the frame reference, the mode field and the alarm and national controls all share the transmit clock. The reference input is not resynchronised.

Frame timing belongs to the upstream source. When the timing field selects slave timing, a rising edge on the reference input marks the current input slot as slot 0 of a new frame. After that the internal position counter runs on its own and wraps every 1536 clocks until the next rising edge. The block raises an overhead indicator one clock before each overhead slot is taken in. The source uses it to hold back its next payload bit.

The line output is registered. A bit presented in clock n appears on the output in clock n+1. Until the first accepted reference edge after reset, the line output idles at one.

Top module: `e3_tx_slave_framer`

## Requirements
- R1: While reset is asserted, and directly after it, `ser_out` is 1 and `oh_ind` is 0.
- R2: Until the first accepted reference edge, `ser_out` stays 1 and `oh_ind` stays 0, whatever `pay_in` does.
- R3: A reference edge is accepted when `timing_sel` is 2'b01 and `ref_in` is 1 after being 0 in the previous clock. The slot of an accepted edge is position 0. Positions 0 to 9 put the alignment word 1111010000 on `ser_out`, leftmost bit first, one clock after each slot.
- R4: Position 10 puts the alarm value and position 11 the national value on `ser_out`. Both values are sampled from `alarm_bit` and `nat_bit` in the position-0 slot. Later changes to those inputs do not affect the current frame.
- R5: Positions 12 to 1535 put the `pay_in` value of that slot on `ser_out` one clock later.
- R6: `pay_in` has no effect on `ser_out` in positions 0 to 11.
- R7: Once framing has started, `oh_ind` is 1 in a clock exactly when the following slot is one of positions 0 to 11, if no new edge arrives. That gives 12 high clocks in each free-running frame.
- R8: With no accepted edge, position 1535 is followed by position 0, so framing repeats every 1536 clocks.
- R9: An accepted edge in mid-frame makes its slot position 0, and the next slot is position 1.
- R10: A reference held high produces no further restarts after its rising edge.
- R11: With `timing_sel` other than 2'b01, reference edges are ignored. They neither start framing nor restart a running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit input clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_sel | input | 2 | Timing-reference select; 2'b01 is slave timing |
| ref_in | input | 1 | Frame reference; rising edge marks slot 0 |
| pay_in | input | 1 | Serial payload bit for the current slot |
| alarm_bit | input | 1 | Alarm bit value, sampled at frame start |
| nat_bit | input | 1 | National bit value, sampled at frame start |
| ser_out | output | 1 | Registered line bit stream |
| oh_ind | output | 1 | High one clock before each overhead slot |

## Verification
The bench sends random payload through the overhead slots. A design that let payload leak into the alignment word or the alarm and national bits would then show wrong bits there. It changes the alarm and national inputs shortly after a frame start. A block that sampled them late would put the new value into the current frame.

The bench also pulses the reference in mid-frame, holds it high for several frames, and pulses it under a non-slave mode, both before and after framing has started. A level-sensitive start would keep resetting the counter. Mode-blind edge detection would either start framing or shift it. A wrong wrap point would drift the alignment word one slot per frame. The bench counts overhead-indicator clocks over a whole frame, which exposes an indicator window that is off by one at either end.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;
    parameter int unsigned E3_FRAME_BITS = 1536;
    parameter int unsigned E3_FAS_BITS   = 10;
    parameter logic [9:0]  E3_FAS_WORD   = 10'b1111010000;

    typedef enum logic [1:0] {
        TREF_LOCAL = 2'b00,
        TREF_SLAVE = 2'b01,
        TREF_RSV2  = 2'b10,
        TREF_RSV3  = 2'b11
    } tref_mode_e;
endpackage

// File: rtl/e3tx_start_detect.sv
module e3tx_start_detect #(
    parameter int unsigned FRAME_BITS = 1536,
    parameter int unsigned POS_W      = 11
) (
    input  logic             ref_in,
    input  logic             ref_prev,
    input  logic [1:0]       timing_sel,
    input  logic [POS_W-1:0] pos_q,
    input  logic             locked_q,
    output logic             start_hit,
    output logic [POS_W-1:0] cur_pos,
    output logic [POS_W-1:0] next_pos,
    output logic             live
);
    import e3tx_pkg::*;

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    always_comb begin
        start_hit = ref_in && !ref_prev && (timing_sel == TREF_SLAVE);
        cur_pos   = start_hit ? '0 : pos_q;
        live      = locked_q || start_hit;
        next_pos  = (cur_pos == LAST_POS) ? '0 : cur_pos + POS_W'(1);
    end
endmodule

// File: rtl/e3tx_bit_select.sv
module e3tx_bit_select #(
    parameter int unsigned FRAME_BITS = 1536,
    parameter int unsigned FAS_BITS   = 10,
    parameter logic [FAS_BITS-1:0] FAS_WORD = 10'b1111010000,
    parameter int unsigned POS_W      = 11
) (
    input  logic             live,
    input  logic [POS_W-1:0] cur_pos,
    input  logic [POS_W-1:0] next_pos,
    input  logic             pay_in,
    input  logic             alarm_q,
    input  logic             nat_q,
    output logic             line_bit,
    output logic             oh_next
);
    localparam int unsigned OH_BITS = FAS_BITS + 2;
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] ALARM_POS = POS_W'(FAS_BITS);
    localparam logic [POS_W-1:0] NAT_POS   = POS_W'(FAS_BITS + 1);
    localparam logic [POS_W-1:0] OH_EDGE   = POS_W'(OH_BITS - 1);

    logic fas_bit;

    always_comb begin
        fas_bit = 1'b1;
        for (int k = 0; k < FAS_BITS; k++) begin
            if (cur_pos == POS_W'(k)) fas_bit = FAS_WORD[FAS_BITS-1-k];
        end
    end

    always_comb begin
        if (!live)                         line_bit = 1'b1;
        else if (cur_pos < ALARM_POS)      line_bit = fas_bit;
        else if (cur_pos == ALARM_POS)     line_bit = alarm_q;
        else if (cur_pos == NAT_POS)       line_bit = nat_q;
        else                               line_bit = pay_in;
        oh_next = live && ((next_pos == LAST_POS) || (next_pos < OH_EDGE));
    end
endmodule

// File: rtl/e3_tx_slave_framer.sv
module e3_tx_slave_framer #(
    parameter int unsigned FRAME_BITS = e3tx_pkg::E3_FRAME_BITS,
    parameter int unsigned FAS_BITS   = e3tx_pkg::E3_FAS_BITS,
    parameter logic [FAS_BITS-1:0] FAS_WORD = e3tx_pkg::E3_FAS_WORD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] timing_sel,
    input  logic       ref_in,
    input  logic       pay_in,
    input  logic       alarm_bit,
    input  logic       nat_bit,
    output logic       ser_out,
    output logic       oh_ind
);
    localparam int unsigned POS_W   = $clog2(FRAME_BITS);
    localparam int unsigned OH_BITS = FAS_BITS + 2;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             ref_prev;
        logic             locked;
        logic             alarm;
        logic             nat;
        logic             ser;
        logic             oh;
    } fr_state_t;

    fr_state_t st_d, st_q;

    logic             start_hit;
    logic             live;
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] next_pos;
    logic             line_bit;
    logic             oh_next;

    logic [POS_W-1:0] pos_q;
    logic             locked_q;
    logic             alarm_q;

    assign pos_q    = st_q.pos;
    assign locked_q = st_q.locked;
    assign alarm_q  = st_q.alarm;

    e3tx_start_detect #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W)
    ) u_start (
        .ref_in     (ref_in),
        .ref_prev   (st_q.ref_prev),
        .timing_sel (timing_sel),
        .pos_q      (st_q.pos),
        .locked_q   (st_q.locked),
        .start_hit  (start_hit),
        .cur_pos    (cur_pos),
        .next_pos   (next_pos),
        .live       (live)
    );

    e3tx_bit_select #(
        .FRAME_BITS (FRAME_BITS),
        .FAS_BITS   (FAS_BITS),
        .FAS_WORD   (FAS_WORD),
        .POS_W      (POS_W)
    ) u_bits (
        .live       (live),
        .cur_pos    (cur_pos),
        .next_pos   (next_pos),
        .pay_in     (pay_in),
        .alarm_q    (st_q.alarm),
        .nat_q      (st_q.nat),
        .line_bit   (line_bit),
        .oh_next    (oh_next)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ref_prev = ref_in;
        st_d.pos      = next_pos;
        st_d.locked   = live;
        if (cur_pos == '0) begin
            st_d.alarm = alarm_bit;
            st_d.nat   = nat_bit;
        end
        st_d.ser = line_bit;
        st_d.oh  = oh_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos      <= '0;
            st_q.ref_prev <= 1'b0;
            st_q.locked   <= 1'b0;
            st_q.alarm    <= 1'b0;
            st_q.nat      <= 1'b0;
            st_q.ser      <= 1'b1;
            st_q.oh       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.ser;
    assign oh_ind  = st_q.oh;

    logic unused_oh_bits;
    assign unused_oh_bits = (OH_BITS == 0);
endmodule

// File: rtl/e3tx_checker.sv
module e3tx_checker #(
    parameter int unsigned FRAME_BITS = 1536,
    parameter int unsigned OH_BITS    = 12,
    parameter int unsigned POS_W      = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       timing_sel,
    input logic             ref_in,
    input logic             alarm_bit,
    input logic             ser_out,
    input logic             oh_ind,
    input logic [POS_W-1:0] pos_q,
    input logic [POS_W-1:0] cur_pos,
    input logic             locked_q,
    input logic             alarm_q,
    input logic             start_hit
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] OH_EDGE  = POS_W'(OH_BITS - 1);

    assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q && !start_hit) |=> ser_out);

    assert_start_fas_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> (ser_out && oh_ind));

    assert_sample_an_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pos == '0) |=> (alarm_q == $past(alarm_bit)));

    assert_oh_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oh_ind |-> (locked_q && ((pos_q == LAST_POS) || (pos_q < OH_EDGE))));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !start_hit && pos_q == LAST_POS) |=> (pos_q == '0));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> (pos_q == POS_W'(1)));

    assert_held_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_in && $past(ref_in) && locked_q && pos_q != LAST_POS)
        |=> (pos_q == $past(pos_q) + POS_W'(1)));

    assert_mode_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_sel != 2'b01 && locked_q && pos_q != LAST_POS)
        |=> (pos_q == $past(pos_q) + POS_W'(1)));
endmodule

bind e3_tx_slave_framer e3tx_checker #(
    .FRAME_BITS (FRAME_BITS),
    .OH_BITS    (OH_BITS),
    .POS_W      (POS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .timing_sel (timing_sel),
    .ref_in     (ref_in),
    .alarm_bit  (alarm_bit),
    .ser_out    (ser_out),
    .oh_ind     (oh_ind),
    .pos_q      (pos_q),
    .cur_pos    (cur_pos),
    .locked_q   (locked_q),
    .alarm_q    (alarm_q),
    .start_hit  (start_hit)
);

// File: tb/test_e3_tx_slave_framer.sv
`timescale 1ns/1ps
module test_e3_tx_slave_framer;
    localparam int FRAME = 1536;
    localparam logic [9:0] FAS = 10'b1111010000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] timing_sel = 2'b01;
    logic       ref_in = 1'b0;
    logic       pay_in = 1'b0;
    logic       alarm_bit = 1'b0;
    logic       nat_bit = 1'b0;
    logic       ser_out;
    logic       oh_ind;

    int total = 0;
    int bad = 0;
    string phase = "R2";
    bit count_en = 0;
    int oh_cnt = 0;

    always #4 clk = ~clk;

    e3_tx_slave_framer i_e3_tx_slave_framer (
        .clk (clk), .rst_n (rst_n), .timing_sel (timing_sel), .ref_in (ref_in),
        .pay_in (pay_in), .alarm_bit (alarm_bit), .nat_bit (nat_bit),
        .ser_out (ser_out), .oh_ind (oh_ind)
    );

    // behavioural reference model
    int    m_pos = 0;
    bit    m_lk = 0, m_prev = 0, m_a = 0, m_n = 0;
    logic  e_ser = 1'b1, e_oh = 1'b0;
    string e_tag = "R2";

    always @(posedge clk) begin : model
        int  cur, nxt;
        bit  hit, lk;
        if (!rst_n) begin
            m_pos = 0; m_lk = 0; m_prev = 0; m_a = 0; m_n = 0;
            e_ser = 1'b1; e_oh = 1'b0; e_tag = "R1";
        end else begin
            hit    = ref_in && !m_prev && (timing_sel == 2'b01);
            m_prev = ref_in;
            cur    = hit ? 0 : m_pos;
            lk     = m_lk || hit;
            if (cur == 0) begin m_a = alarm_bit; m_n = nat_bit; end
            if (!lk)            begin e_ser = 1'b1;        e_tag = "R2"; end
            else if (cur < 10)  begin e_ser = FAS[9-cur];  e_tag = "R3/R6"; end
            else if (cur == 10) begin e_ser = m_a;         e_tag = "R4/R6"; end
            else if (cur == 11) begin e_ser = m_n;         e_tag = "R4/R6"; end
            else                begin e_ser = pay_in;      e_tag = "R5"; end
            nxt  = (cur == FRAME-1) ? 0 : cur + 1;
            e_oh = lk && (nxt == FRAME-1 || nxt <= 10);
            m_pos = nxt;
            m_lk  = lk;
        end
    end

    task automatic check(string tag, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            check({phase, " ser ", e_tag}, ser_out, e_ser);
            check({phase, " oh R7"}, oh_ind, e_oh);
            if (count_en && oh_ind) oh_cnt++;
        end
        pay_in = 1'($urandom_range(0, 1));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_ref();
        ref_in = 1'b1; tick(); ref_in = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run(3);
        check("R1 ser in reset", ser_out, 1'b1);
        check("R1 oh in reset", oh_ind, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1 ser after reset", ser_out, 1'b1);
        check("R1 oh after reset", oh_ind, 1'b0);

        phase = "R2"; run(40);

        phase = "R11 unlocked"; timing_sel = 2'b00; pulse_ref(); run(30);
        timing_sel = 2'b10; pulse_ref(); run(30);
        check("R11 still idle", ser_out, 1'b1);

        phase = "R3"; timing_sel = 2'b01; alarm_bit = 1'b1; nat_bit = 1'b0;
        pulse_ref(); run(3);
        alarm_bit = 1'b0; nat_bit = 1'b1;       // R4: too late for this frame
        run(20);
        phase = "R8"; run(FRAME - 30 + 6);
        count_en = 1; oh_cnt = 0; run(FRAME); count_en = 0;
        check("R7 oh clocks per frame", 1'(oh_cnt == 12), 1'b1);
        if (oh_cnt != 12) $display("  R7 count=%0d expected=12", oh_cnt);

        phase = "R9"; run(700); alarm_bit = 1'b1; pulse_ref(); run(FRAME + 40);

        phase = "R10"; ref_in = 1'b1; run(2 * FRAME + 500); ref_in = 1'b0; run(50);

        phase = "R11 locked"; timing_sel = 2'b00; run(300); pulse_ref(); run(400);
        timing_sel = 2'b11; pulse_ref(); run(FRAME);
        timing_sel = 2'b01; phase = "R6"; run(FRAME);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule